// File: doc/BRIEF.md
# Card Command Launcher with Response Capture

This block is the command half of a memory-card host controller. Software loads a command index and a 32-bit argument, the argument in two 16-bit halves. It then writes a mode word. The mode word selects the expected response class, whether a data phase follows, and whether a stop-transfer is pending. When the card clock is running and no stop-transfer is pending, the block offers the index and argument to a card-side port through a valid/ready handshake. It then waits for that port to return a response.

The card side returns its response as a parallel byte vector with a byte count and a timeout flag. The block packs the bytes two per halfword into a nine-entry response queue, which software drains one halfword per read. On completion the block raises a command-done request and a response-ended status, and it flags a timeout when the card gave no answer. For commands with a data phase, it preloads the remaining-byte counter used by the data path.

Top module: `sdcmd_issue`

## Requirements
- R1: A write of the index register keeps only bits [5:0]. `idx_rdata` returns the stored index with bit 6 set and bit 7 clear, so a zero index reads as 0x40.
- R2: A write of the high half replaces argument bits [31:16] and a write of the low half replaces bits [15:0]. `arg_lo_rdata` shows bits [15:0], and `card_req_arg` carries the full 32-bit value.
- R3: A `clk_start` pulse sets `clk_en` and clears `clk_off_irq`. A `clk_stop` pulse clears `clk_en` and sets `clk_off_irq`. When both pulse in the same cycle, the stop wins.
- R4: The mode word is laid out as [1:0] response class (0 none, 1 short, 2 long, 3 short-alt), [2] data enable and [3] stop-transfer. Writing it marks a command pending. If `clk_en` is set, the written stop bit is 0 and the block is idle, the command launches in that cycle.
- R5: A `clk_start` pulse launches a pending command when the stored stop bit is 0 and the block is idle. A pending command with the stop bit set is not launched.
- R6: After launch, `card_req_valid` stays high with a stable index and argument until a cycle with `card_req_ready` high.
- R7: A response is captured in the cycle `card_rsp_valid` is high. Halfword i holds response byte 2i in [7:0] and byte 2i+1 in [15:8], where byte b is `card_rsp_data[8b+7:8b]`. Bytes at or beyond `card_rsp_len` read as zero. Class 0 stores nothing, classes 1 and 3 store at most three halfwords, and class 2 stores all nine.
- R8: A launch zeroes all nine halfwords and resets the read position to halfword 0.
- R9: `rsp_rdata` shows the halfword at the read position. Each `rsp_pop` advances the position, and once nine halfwords have been consumed the output reads zero.
- R10: A completion sets `end_cmd_irq` and `end_rsp`, and a launch clears both.
- R11: A completion with `card_rsp_tout` high and a nonzero response class sets `rsp_tout_flag`. With class 0 the timeout is ignored. A launch clears the flag.
- R12: A completion with data enable set and no counted timeout loads `bytes_left` with block count (16 bits) times block length (12 bits). Otherwise `bytes_left` is unchanged.
- R13: While a command is in flight (`busy` high), mode writes and `clk_start` pulses launch nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdata | input | 16 | Write data shared by all register strobes |
| wr_idx | input | 1 | Write command index |
| wr_arg_hi | input | 1 | Write argument bits [31:16] |
| wr_arg_lo | input | 1 | Write argument bits [15:0] |
| wr_mode | input | 1 | Write mode word |
| wr_blklen | input | 1 | Write block length |
| wr_blkcnt | input | 1 | Write block count |
| clk_start | input | 1 | Start card clock |
| clk_stop | input | 1 | Stop card clock |
| rsp_pop | input | 1 | Advance response read position |
| idx_rdata | output | 8 | Index readback with start bits |
| arg_lo_rdata | output | 16 | Argument low-half readback |
| rsp_rdata | output | 16 | Halfword at response read position |
| clk_en | output | 1 | Card clock enabled status |
| clk_off_irq | output | 1 | Clock-off interrupt request |
| end_cmd_irq | output | 1 | Command-done interrupt request |
| end_rsp | output | 1 | Response-ended status |
| rsp_tout_flag | output | 1 | Response timeout status |
| busy | output | 1 | Command in flight |
| bytes_left | output | 28 | Remaining data byte counter |
| card_req_valid | output | 1 | Command offered to card port |
| card_req_ready | input | 1 | Card port accepts command |
| card_req_idx | output | 6 | Command index to card |
| card_req_arg | output | 32 | Command argument to card |
| card_rsp_valid | input | 1 | Card response present |
| card_rsp_len | input | 5 | Number of response bytes |
| card_rsp_tout | input | 1 | Card gave no response |
| card_rsp_data | input | 144 | Response bytes, byte b at [8b+7:8b] |

## Verification
The bound checker watches on every cycle the things that follow from a single strobe or edge. These are the index and low-argument readback after a write, the clock start/stop effects, the request held until accepted, and that the done and timeout flags rise only after a card response or card timeout. It also checks that a request starts only from idle with the flags already cleared. The bench scenarios are needed for the rest: response packing by class and byte count, zeroing of the queue at launch, reads past the ninth entry, the byte-counter product, and the pending-command rules under stop-transfer and busy conditions.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_SHORT = 2'd1,
    RSP_LONG  = 2'd2,
    RSP_ALT   = 2'd3
  } rsp_kind_e;

  // mode word: [3] stop-transfer, [2] data enable, [1:0] response class
  typedef struct packed {
    logic      stop_xfer;
    logic      data_en;
    rsp_kind_e kind;
  } mode_t;

  localparam int MODE_W = 4;

endpackage

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
  import sdcmd_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int ARG_W    = 32,
  parameter int BLKLEN_W = 12,
  parameter int BLKCNT_W = 16,
  localparam int HALF_W  = ARG_W / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HALF_W-1:0]   wdata,
  input  logic                wr_idx,
  input  logic                wr_arg_hi,
  input  logic                wr_arg_lo,
  input  logic                wr_mode,
  input  logic                wr_blklen,
  input  logic                wr_blkcnt,
  output logic [IDX_W-1:0]    idx_q,
  output logic [ARG_W-1:0]    arg_q,
  output mode_t               mode_q,
  output logic [BLKLEN_W-1:0] blklen_q,
  output logic [BLKCNT_W-1:0] blkcnt_q
);

  logic [IDX_W-1:0]    idx_d;
  logic [ARG_W-1:0]    arg_d;
  mode_t               mode_d;
  logic [BLKLEN_W-1:0] blklen_d;
  logic [BLKCNT_W-1:0] blkcnt_d;

  always_comb begin
    idx_d    = idx_q;
    arg_d    = arg_q;
    mode_d   = mode_q;
    blklen_d = blklen_q;
    blkcnt_d = blkcnt_q;
    if (wr_idx)    idx_d = wdata[IDX_W-1:0];
    if (wr_arg_hi) arg_d[ARG_W-1:HALF_W] = wdata;
    if (wr_arg_lo) arg_d[HALF_W-1:0] = wdata;
    if (wr_mode)   mode_d = mode_t'(wdata[MODE_W-1:0]);
    if (wr_blklen) blklen_d = wdata[BLKLEN_W-1:0];
    if (wr_blkcnt) blkcnt_d = wdata[BLKCNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      arg_q    <= '0;
      mode_q   <= '0;
      blklen_q <= '0;
      blkcnt_q <= '0;
    end else begin
      idx_q    <= idx_d;
      arg_q    <= arg_d;
      mode_q   <= mode_d;
      blklen_q <= blklen_d;
      blkcnt_q <= blkcnt_d;
    end
  end

endmodule

// File: rtl/sdcmd_rsp_fifo.sv
module sdcmd_rsp_fifo
  import sdcmd_pkg::*;
#(
  parameter int RSP_HW    = 9,
  parameter int SHORT_HW  = 3,
  localparam int RSP_BYTES = RSP_HW * 2,
  localparam int LEN_W    = $clog2(RSP_BYTES + 1),
  localparam int RD_W     = $clog2(RSP_HW + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   launch,
  input  logic                   capture,
  input  rsp_kind_e              kind,
  input  logic [LEN_W-1:0]       rsp_len,
  input  logic [RSP_BYTES*8-1:0] rsp_data,
  input  logic                   pop,
  output logic [15:0]            rdata
);

  logic [RSP_HW-1:0][15:0] hw_q, hw_d;
  logic [RD_W-1:0]         rd_q, rd_d;
  int                      lim;

  always_comb begin
    case (kind)
      RSP_NONE: lim = 0;
      RSP_LONG: lim = RSP_BYTES;
      default:  lim = SHORT_HW * 2;
    endcase
  end

  always_comb begin
    hw_d = hw_q;
    if (launch) begin
      hw_d = '0;
    end else if (capture) begin
      for (int h = 0; h < RSP_HW; h++) begin
        for (int k = 0; k < 2; k++) begin
          if ((2*h + k) < int'(rsp_len) && (2*h + k) < lim)
            hw_d[h][k*8 +: 8] = rsp_data[(2*h + k)*8 +: 8];
          else
            hw_d[h][k*8 +: 8] = 8'h00;
        end
      end
    end
  end

  always_comb begin
    rd_d = rd_q;
    if (launch)
      rd_d = '0;
    else if (pop && (int'(rd_q) < RSP_HW))
      rd_d = rd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q <= '0;
      rd_q <= '0;
    end else begin
      hw_q <= hw_d;
      rd_q <= rd_d;
    end
  end

  assign rdata = (int'(rd_q) < RSP_HW) ? hw_q[rd_q] : 16'h0000;

endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
#(
  parameter int BLKLEN_W = 12,
  parameter int BLKCNT_W = 16,
  localparam int CNT_W   = BLKLEN_W + BLKCNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_start,
  input  logic                clk_stop,
  input  logic                wr_mode,
  input  mode_t               new_mode,
  input  mode_t               mode_q,
  input  logic [BLKLEN_W-1:0] blklen_q,
  input  logic [BLKCNT_W-1:0] blkcnt_q,
  input  logic                card_req_ready,
  input  logic                card_rsp_valid,
  input  logic                card_rsp_tout,
  output logic                launch,
  output logic                capture,
  output logic                card_req_valid,
  output logic                clk_en,
  output logic                clk_off_irq,
  output logic                end_cmd_irq,
  output logic                end_rsp,
  output logic                rsp_tout_flag,
  output logic                busy,
  output logic [CNT_W-1:0]    bytes_left
);

  seq_state_e       st_q, st_d;
  logic             pend_q, pend_d;
  logic             clk_en_d, clk_off_d;
  logic             end_cmd_d, end_rsp_d, tout_d;
  logic [CNT_W-1:0] bytes_d;
  logic             idle, tout_hit;

  assign idle     = (st_q == SEQ_IDLE);
  assign launch   = idle && ((wr_mode && clk_en && !new_mode.stop_xfer) ||
                             (clk_start && pend_q && !mode_q.stop_xfer));
  assign capture  = (st_q == SEQ_WAIT) && card_rsp_valid;
  assign tout_hit = card_rsp_tout && (mode_q.kind != RSP_NONE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      SEQ_IDLE: if (launch) st_d = SEQ_REQ;
      SEQ_REQ:  if (card_req_ready) st_d = SEQ_WAIT;
      SEQ_WAIT: if (card_rsp_valid) st_d = SEQ_IDLE;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (launch)       pend_d = 1'b0;
    else if (wr_mode) pend_d = 1'b1;

    clk_en_d  = clk_en;
    clk_off_d = clk_off_irq;
    if (clk_start) begin
      clk_en_d  = 1'b1;
      clk_off_d = 1'b0;
    end
    if (clk_stop) begin
      clk_en_d  = 1'b0;
      clk_off_d = 1'b1;
    end

    end_cmd_d = end_cmd_irq;
    end_rsp_d = end_rsp;
    tout_d    = rsp_tout_flag;
    bytes_d   = bytes_left;
    if (launch) begin
      end_cmd_d = 1'b0;
      end_rsp_d = 1'b0;
      tout_d    = 1'b0;
    end else if (capture) begin
      end_cmd_d = 1'b1;
      end_rsp_d = 1'b1;
      if (tout_hit) tout_d = 1'b1;
      if (mode_q.data_en && !tout_hit)
        bytes_d = CNT_W'(blkcnt_q) * CNT_W'(blklen_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= SEQ_IDLE;
      pend_q        <= 1'b0;
      clk_en        <= 1'b0;
      clk_off_irq   <= 1'b0;
      end_cmd_irq   <= 1'b0;
      end_rsp       <= 1'b0;
      rsp_tout_flag <= 1'b0;
      bytes_left    <= '0;
    end else begin
      st_q          <= st_d;
      pend_q        <= pend_d;
      clk_en        <= clk_en_d;
      clk_off_irq   <= clk_off_d;
      end_cmd_irq   <= end_cmd_d;
      end_rsp       <= end_rsp_d;
      rsp_tout_flag <= tout_d;
      bytes_left    <= bytes_d;
    end
  end

  assign card_req_valid = (st_q == SEQ_REQ);
  assign busy           = !idle;

endmodule

// File: rtl/sdcmd_issue.sv
module sdcmd_issue
  import sdcmd_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  parameter int BLKLEN_W  = 12,
  parameter int BLKCNT_W  = 16,
  parameter int RSP_HW    = 9,
  parameter int SHORT_HW  = 3,
  localparam int HALF_W    = ARG_W / 2,
  localparam int RSP_BYTES = RSP_HW * 2,
  localparam int LEN_W     = $clog2(RSP_BYTES + 1),
  localparam int CNT_W     = BLKLEN_W + BLKCNT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [HALF_W-1:0]      wdata,
  input  logic                   wr_idx,
  input  logic                   wr_arg_hi,
  input  logic                   wr_arg_lo,
  input  logic                   wr_mode,
  input  logic                   wr_blklen,
  input  logic                   wr_blkcnt,
  input  logic                   clk_start,
  input  logic                   clk_stop,
  input  logic                   rsp_pop,
  output logic [IDX_W+1:0]       idx_rdata,
  output logic [HALF_W-1:0]      arg_lo_rdata,
  output logic [15:0]            rsp_rdata,
  output logic                   clk_en,
  output logic                   clk_off_irq,
  output logic                   end_cmd_irq,
  output logic                   end_rsp,
  output logic                   rsp_tout_flag,
  output logic                   busy,
  output logic [CNT_W-1:0]       bytes_left,
  output logic                   card_req_valid,
  input  logic                   card_req_ready,
  output logic [IDX_W-1:0]       card_req_idx,
  output logic [ARG_W-1:0]       card_req_arg,
  input  logic                   card_rsp_valid,
  input  logic [LEN_W-1:0]       card_rsp_len,
  input  logic                   card_rsp_tout,
  input  logic [RSP_BYTES*8-1:0] card_rsp_data
);

  logic [IDX_W-1:0]    idx_q;
  logic [ARG_W-1:0]    arg_q;
  mode_t               mode_q;
  logic [BLKLEN_W-1:0] blklen_q;
  logic [BLKCNT_W-1:0] blkcnt_q;
  logic                launch, capture;

  sdcmd_regs #(
    .IDX_W(IDX_W), .ARG_W(ARG_W), .BLKLEN_W(BLKLEN_W), .BLKCNT_W(BLKCNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wdata(wdata),
    .wr_idx(wr_idx), .wr_arg_hi(wr_arg_hi), .wr_arg_lo(wr_arg_lo),
    .wr_mode(wr_mode), .wr_blklen(wr_blklen), .wr_blkcnt(wr_blkcnt),
    .idx_q(idx_q), .arg_q(arg_q), .mode_q(mode_q),
    .blklen_q(blklen_q), .blkcnt_q(blkcnt_q)
  );

  sdcmd_seq #(
    .BLKLEN_W(BLKLEN_W), .BLKCNT_W(BLKCNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .clk_start(clk_start), .clk_stop(clk_stop),
    .wr_mode(wr_mode), .new_mode(mode_t'(wdata[MODE_W-1:0])),
    .mode_q(mode_q), .blklen_q(blklen_q), .blkcnt_q(blkcnt_q),
    .card_req_ready(card_req_ready), .card_rsp_valid(card_rsp_valid),
    .card_rsp_tout(card_rsp_tout),
    .launch(launch), .capture(capture), .card_req_valid(card_req_valid),
    .clk_en(clk_en), .clk_off_irq(clk_off_irq), .end_cmd_irq(end_cmd_irq),
    .end_rsp(end_rsp), .rsp_tout_flag(rsp_tout_flag), .busy(busy),
    .bytes_left(bytes_left)
  );

  sdcmd_rsp_fifo #(
    .RSP_HW(RSP_HW), .SHORT_HW(SHORT_HW)
  ) u_rsp (
    .clk(clk), .rst_n(rst_n), .launch(launch), .capture(capture),
    .kind(mode_q.kind), .rsp_len(card_rsp_len), .rsp_data(card_rsp_data),
    .pop(rsp_pop), .rdata(rsp_rdata)
  );

  assign idx_rdata    = {2'b01, idx_q};
  assign arg_lo_rdata = arg_q[HALF_W-1:0];
  assign card_req_idx = idx_q;
  assign card_req_arg = arg_q;

endmodule

// File: rtl/sdcmd_issue_chk.sv
module sdcmd_issue_chk #(
  parameter int IDX_W  = 6,
  parameter int HALF_W = 16,
  parameter int ARG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HALF_W-1:0] wdata,
  input logic              wr_idx,
  input logic              wr_arg_hi,
  input logic              wr_arg_lo,
  input logic              clk_start,
  input logic              clk_stop,
  input logic [IDX_W+1:0]  idx_rdata,
  input logic [HALF_W-1:0] arg_lo_rdata,
  input logic              clk_en,
  input logic              clk_off_irq,
  input logic              end_cmd_irq,
  input logic              rsp_tout_flag,
  input logic              busy,
  input logic              card_req_valid,
  input logic              card_req_ready,
  input logic [IDX_W-1:0]  card_req_idx,
  input logic [ARG_W-1:0]  card_req_arg,
  input logic              card_rsp_valid,
  input logic              card_rsp_tout
);

  // R1
  idx_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> idx_rdata == {2'b01, $past(wdata[IDX_W-1:0])});

  // R2
  arg_lo_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_arg_lo |=> arg_lo_rdata == $past(wdata));

  // R3
  clk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |=> !clk_en && clk_off_irq);

  // R3
  clk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_start && !clk_stop) |=> clk_en && !clk_off_irq);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_req_valid && !card_req_ready) |=> card_req_valid);

  // R6
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_req_valid && !card_req_ready && !wr_idx && !wr_arg_hi && !wr_arg_lo)
      |=> $stable(card_req_idx) && $stable(card_req_arg));

  // R10
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_cmd_irq) |-> $past(card_rsp_valid));

  // R11
  tout_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_tout_flag) |-> $past(card_rsp_tout));

  // R13
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_req_valid) |-> !$past(busy));

  // R10
  flags_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_req_valid) |-> !end_cmd_irq && !rsp_tout_flag);

endmodule

bind sdcmd_issue sdcmd_issue_chk #(
  .IDX_W(IDX_W), .HALF_W(HALF_W), .ARG_W(ARG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wdata(wdata), .wr_idx(wr_idx),
  .wr_arg_hi(wr_arg_hi), .wr_arg_lo(wr_arg_lo),
  .clk_start(clk_start), .clk_stop(clk_stop),
  .idx_rdata(idx_rdata), .arg_lo_rdata(arg_lo_rdata),
  .clk_en(clk_en), .clk_off_irq(clk_off_irq), .end_cmd_irq(end_cmd_irq),
  .rsp_tout_flag(rsp_tout_flag), .busy(busy),
  .card_req_valid(card_req_valid), .card_req_ready(card_req_ready),
  .card_req_idx(card_req_idx), .card_req_arg(card_req_arg),
  .card_rsp_valid(card_rsp_valid), .card_rsp_tout(card_rsp_tout)
);

// File: tb/sdcmd_issue_bench.sv
`timescale 1ns/1ps
module sdcmd_issue_bench;

  localparam int NHW = 9;
  localparam int NB  = NHW * 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [15:0]   wdata;
  logic          wr_idx, wr_arg_hi, wr_arg_lo, wr_mode, wr_blklen, wr_blkcnt;
  logic          clk_start, clk_stop, rsp_pop;
  logic [7:0]    idx_rdata;
  logic [15:0]   arg_lo_rdata, rsp_rdata;
  logic          clk_en, clk_off_irq, end_cmd_irq, end_rsp, rsp_tout_flag, busy;
  logic [27:0]   bytes_left;
  logic          card_req_valid, card_req_ready;
  logic [5:0]    card_req_idx;
  logic [31:0]   card_req_arg;
  logic          card_rsp_valid, card_rsp_tout;
  logic [4:0]    card_rsp_len;
  logic [NB*8-1:0] card_rsp_data;

  sdcmd_issue u_sdcmd_issue (
    .clk(clk), .rst_n(rst_n), .wdata(wdata),
    .wr_idx(wr_idx), .wr_arg_hi(wr_arg_hi), .wr_arg_lo(wr_arg_lo),
    .wr_mode(wr_mode), .wr_blklen(wr_blklen), .wr_blkcnt(wr_blkcnt),
    .clk_start(clk_start), .clk_stop(clk_stop), .rsp_pop(rsp_pop),
    .idx_rdata(idx_rdata), .arg_lo_rdata(arg_lo_rdata), .rsp_rdata(rsp_rdata),
    .clk_en(clk_en), .clk_off_irq(clk_off_irq), .end_cmd_irq(end_cmd_irq),
    .end_rsp(end_rsp), .rsp_tout_flag(rsp_tout_flag), .busy(busy),
    .bytes_left(bytes_left), .card_req_valid(card_req_valid),
    .card_req_ready(card_req_ready), .card_req_idx(card_req_idx),
    .card_req_arg(card_req_arg), .card_rsp_valid(card_rsp_valid),
    .card_rsp_len(card_rsp_len), .card_rsp_tout(card_rsp_tout),
    .card_rsp_data(card_rsp_data)
  );

  int tests = 0;
  int fails = 0;
  logic [27:0] exp_bytes = '0;

  localparam int S_IDX = 0, S_HI = 1, S_LO = 2, S_MODE = 3, S_BLEN = 4,
                 S_BCNT = 5, S_START = 6, S_STOP = 7, S_POP = 8;

  // {kind[8:7], data_en[6], tout[5], len[4:0]}
  localparam logic [8:0] VEC [8] = '{
    {2'd1, 1'b0, 1'b0, 5'd6},
    {2'd2, 1'b0, 1'b0, 5'd17},
    {2'd0, 1'b0, 1'b0, 5'd0},
    {2'd3, 1'b1, 1'b0, 5'd6},
    {2'd1, 1'b1, 1'b1, 5'd0},
    {2'd2, 1'b1, 1'b0, 5'd10},
    {2'd1, 1'b0, 1'b0, 5'd17},
    {2'd0, 1'b1, 1'b1, 5'd6}
  };

  function automatic logic [7:0] pat(input int b);
    return 8'((b * 29) + 7);
  endfunction

  // R7 model: byte kept when below length and below the class limit
  function automatic logic [15:0] exp_hw(input int h, input int kind, input int len);
    int lim;
    logic [15:0] v;
    lim = (kind == 0) ? 0 : ((kind == 2) ? NB : 6);
    v = '0;
    for (int k = 0; k < 2; k++)
      if ((2*h + k) < len && (2*h + k) < lim) v[k*8 +: 8] = pat(2*h + k);
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [15:0] d);
    @(negedge clk);
    wdata = d;
    case (sel)
      S_IDX:   wr_idx = 1'b1;
      S_HI:    wr_arg_hi = 1'b1;
      S_LO:    wr_arg_lo = 1'b1;
      S_MODE:  wr_mode = 1'b1;
      S_BLEN:  wr_blklen = 1'b1;
      S_BCNT:  wr_blkcnt = 1'b1;
      S_START: clk_start = 1'b1;
      S_STOP:  clk_stop = 1'b1;
      default: rsp_pop = 1'b1;
    endcase
    @(negedge clk);
    {wr_idx, wr_arg_hi, wr_arg_lo, wr_mode, wr_blklen, wr_blkcnt} = '0;
    {clk_start, clk_stop, rsp_pop} = '0;
  endtask

  // accept request after 'delay' cycles, then return a response
  task automatic serve(input int delay, input int len, input logic tout);
    for (int d = 0; d < delay; d++) begin
      @(negedge clk);
      check("R6 hold", {63'd0, card_req_valid}, 64'd1);
    end
    card_req_ready = 1'b1;
    @(negedge clk);
    card_req_ready = 1'b0;
    card_rsp_valid = 1'b1;
    card_rsp_len = 5'(len);
    card_rsp_tout = tout;
    @(negedge clk);
    card_rsp_valid = 1'b0;
    card_rsp_tout = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wdata = '0;
    {wr_idx, wr_arg_hi, wr_arg_lo, wr_mode, wr_blklen, wr_blkcnt} = '0;
    {clk_start, clk_stop, rsp_pop} = '0;
    card_req_ready = 1'b0;
    card_rsp_valid = 1'b0;
    card_rsp_tout = 1'b0;
    card_rsp_len = '0;
    for (int b = 0; b < NB; b++) card_rsp_data[b*8 +: 8] = pat(b);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R3 reset clk_en", {63'd0, clk_en}, 64'd0);
    check("R13 reset busy", {63'd0, busy}, 64'd0);
    check("R6 reset req", {63'd0, card_req_valid}, 64'd0);
    check("R10 reset done", {62'd0, end_cmd_irq, end_rsp}, 64'd0);
    check("R12 reset bytes", {36'd0, bytes_left}, 64'd0);
    check("R1 reset readback", {56'd0, idx_rdata}, 64'h40);

    // R1 / R2 register writes
    wr(S_IDX, 16'h00FF);
    check("R1 index mask", {56'd0, idx_rdata}, 64'h7F);
    wr(S_HI, 16'hDEAD);
    wr(S_LO, 16'hBEEF);
    check("R2 arg low", {48'd0, arg_lo_rdata}, 64'hBEEF);

    // R4 mode written with clock off: no launch
    wr(S_MODE, 16'h0001);
    check("R4 no launch clk off", {62'd0, card_req_valid, busy}, 64'd0);
    // R5 clock start launches pending command
    wr(S_START, 16'h0000);
    check("R3 start clk_en", {62'd0, clk_en, clk_off_irq}, 64'b10);
    check("R5 launch on start", {63'd0, card_req_valid}, 64'd1);
    check("R2 full arg", {32'd0, card_req_arg}, 64'hDEADBEEF);
    check("R1 req index", {58'd0, card_req_idx}, 64'h3F);
    serve(3, 6, 1'b0);
    check("R10 done", {62'd0, end_cmd_irq, end_rsp}, 64'b11);

    // R4 / R5 stop-transfer blocks launch
    wr(S_MODE, 16'h0009);
    check("R4 stop blocks mode launch", {63'd0, card_req_valid}, 64'd0);
    wr(S_START, 16'h0000);
    check("R5 stop blocks start launch", {63'd0, card_req_valid}, 64'd0);

    // table-driven commands
    wr(S_BLEN, 16'h0200);
    for (int i = 0; i < 8; i++) begin
      int kind, len;
      logic de, to;
      kind = int'(VEC[i][8:7]);
      de   = VEC[i][6];
      to   = VEC[i][5];
      len  = int'(VEC[i][4:0]);
      wr(S_BCNT, 16'(i + 2));
      wr(S_IDX, 16'(8'h10 + i));
      wr(S_HI, 16'(i));
      wr(S_LO, 16'(16'h1000 + i));
      wr(S_MODE, {12'd0, 1'b0, de, 2'(kind)});
      check("R4 launch on mode", {63'd0, card_req_valid}, 64'd1);
      check("R10 cleared at launch", {61'd0, end_cmd_irq, end_rsp, rsp_tout_flag}, 64'd0);
      check("R2 table arg", {32'd0, card_req_arg}, {32'd0, 16'(i), 16'(16'h1000 + i)});
      serve(i % 3, len, to);
      check("R10 table done", {62'd0, end_cmd_irq, end_rsp}, 64'b11);
      check("R11 timeout flag", {63'd0, rsp_tout_flag}, {63'd0, (to && kind != 0)});
      if (de && !(to && kind != 0)) exp_bytes = 28'((i + 2) * 512);
      check("R12 byte counter", {36'd0, bytes_left}, {36'd0, exp_bytes});
      for (int h = 0; h < NHW; h++) begin
        check("R7 halfword", {48'd0, rsp_rdata}, {48'd0, exp_hw(h, kind, len)});
        wr(S_POP, 16'h0000);
      end
      check("R9 past end", {48'd0, rsp_rdata}, 64'd0);
    end

    // R8: long response left unread, next launch zeroes it
    wr(S_MODE, 16'h0002);
    serve(0, 17, 1'b0);
    check("R7 long first", {48'd0, rsp_rdata}, {48'd0, exp_hw(0, 2, 17)});
    wr(S_POP, 16'h0000);
    wr(S_MODE, 16'h0002);
    check("R8 zeroed at launch", {48'd0, rsp_rdata}, 64'd0);
    serve(0, 4, 1'b0);
    check("R8 read position reset", {48'd0, rsp_rdata}, {48'd0, exp_hw(0, 2, 4)});
    // R9 repeated pops past end stay zero
    for (int p = 0; p < 11; p++) wr(S_POP, 16'h0000);
    check("R9 saturated", {48'd0, rsp_rdata}, 64'd0);

    // R13 mode and start during a command launch nothing
    wr(S_MODE, 16'h0001);
    card_req_ready = 1'b1;
    @(negedge clk);
    card_req_ready = 1'b0;
    wr(S_MODE, 16'h0001);
    wr(S_START, 16'h0000);
    check("R13 busy in flight", {63'd0, busy}, 64'd1);
    card_rsp_valid = 1'b1;
    card_rsp_len = 5'd6;
    @(negedge clk);
    card_rsp_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R13 no relaunch", {62'd0, card_req_valid, busy}, 64'd0);

    // R3 start and stop together: stop wins
    @(negedge clk);
    clk_start = 1'b1;
    clk_stop = 1'b1;
    @(negedge clk);
    clk_start = 1'b0;
    clk_stop = 1'b0;
    check("R3 stop wins", {62'd0, clk_en, clk_off_irq}, 64'b01);
    wr(S_START, 16'h0000);
    check("R3 restart", {62'd0, clk_en, clk_off_irq}, 64'b10);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule